// File: doc/BRIEF.md
# Strided Memory Pattern Tester

This block is a self-test engine for a region of external RAM. When started, it takes a base byte address and a region size and walks the region in two passes through a word-wide request port. Each word it touches is 32 bytes past the previous one. The first pass writes a pattern word to every tested location. Only after every write has been accepted does the second pass begin. That pass reads the same locations back and compares each word with the pattern it should hold.

The pattern for a location is its word index from the region start XORed with an alternating-bit constant. Each mismatch increments an error counter. The first failing address is latched, and a small log holds the address, read value and expected value of the earliest failures. If the requested size is larger than the addressable window, the run is clamped to the whole window. When the run ends, the engine raises `done` and sets a pass/fail verdict. The verdict, the counts and the log stay readable until the next start.

The request port carries one transaction at a time. The engine holds its request until ready is seen. For a read, it then waits for a response strobe before it moves on.

Top module: `mem_stride_bist`

## Requirements
- R1: For an effective base B and size S, both passes touch exactly the words at byte address B + 32*k for k = 0 .. N-1, with N = S >> 5. No other word in memory is written.
- R2: The word written at step k has word index p = 8*k and value p XOR 32'hAAAAAAAA. The read pass expects that same value at that address.
- R3: Every write of a run is accepted before the first read request of that run is accepted.
- R4: Each read word that differs from its expected value adds one to `err_count`. `first_err_addr` is set to B + 32*k of the first mismatch, and only when `err_count` goes from 0 to 1. A new start clears both to 0.
- R5: The first 3 mismatches of a run are recorded as (address, value read, value expected). Entry i is selected with `log_sel` = i (0, 1 or 2) and appears on `log_addr`, `log_rdata` and `log_expected` one clock later. `log_count` equals the smaller of `err_count` and 3. Mismatches after the third are only counted.
- R6: If `cfg_size` is greater than the window span (WIN_HI - WIN_LO, 0x1000 by default), the run uses base WIN_LO (0x1000 by default) and size equal to the span. Otherwise it uses `cfg_base` and `cfg_size` unchanged.
- R7: At the end of the read pass, `done` rises. `pass` is 1 only if `err_count` is 0.
- R8: `start` is ignored while `busy` is 1. `done`, `pass`, `err_count`, `first_err_addr` and the log keep their values until the next accepted start, and an accepted start clears `done`.
- R9: At most one request is outstanding. While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request (valid, address, write enable, write data) stays unchanged. A read completes on the first `mem_rsp_valid` after its acceptance.
- R10: `words_total` equals the effective size >> 5 from the cycle after the accepted start. A size below 32 gives 0 words, writes nothing and ends with `pass` = 1.
- R11: After reset, `busy`, `done`, `pass`, `err_count` and `mem_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a run, taken only when idle |
| cfg_base | input | 32 | Region base byte address |
| cfg_size | input | 32 | Region size in bytes |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Verdict, valid while done |
| err_count | output | 27 | Number of mismatching words |
| first_err_addr | output | 32 | Byte address of the first mismatch |
| words_total | output | 27 | Number of words tested in the run |
| log_count | output | 2 | Number of valid log entries |
| log_sel | input | 2 | Log entry to read out |
| log_addr | output | 32 | Address of selected log entry |
| log_rdata | output | 32 | Value read for selected entry |
| log_expected | output | 32 | Value expected for selected entry |

## Verification
- `words_total` is due one clock after the start edge.
- A write takes two cycles when ready is high: an issue cycle and an accept cycle. A read takes three cycles or more: issue, accept and response.
- `done`, `pass` and the final counts change one clock after the response that completes the last compare. The bench therefore polls `done` at falling edges and reads every result only after `done` is seen.
- A log entry is due one clock after `log_sel` changes. The bench changes `log_sel` at a falling edge and samples at the next falling edge.
- The hold checks for `done` and `pass`, and the stall checks, are sampled a fixed number of cycles later while inputs are held.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [2:0] {
    MST_IDLE,
    MST_W_ISSUE,
    MST_W_WAIT,
    MST_R_ISSUE,
    MST_R_WAIT,
    MST_R_RESP,
    MST_FINISH
  } mst_state_e;

endpackage

// File: rtl/mst_cfg_clamp.sv
module mst_cfg_clamp #(
  parameter int AW           = 32,
  parameter int STRIDE_SHIFT = 5,
  parameter int CNT_W        = AW - STRIDE_SHIFT,
  parameter logic [AW-1:0] WIN_LO = 32'h0000_1000,
  parameter logic [AW-1:0] WIN_HI = 32'h0000_2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_size,
  output logic [AW-1:0]    eff_base,
  output logic [CNT_W-1:0] eff_steps
);

  localparam logic [AW-1:0] SPAN = WIN_HI - WIN_LO;

  logic          over;
  logic [AW-1:0] base_c;
  logic [AW-1:0] size_c;

  always_comb begin
    over   = (cfg_size > SPAN);
    base_c = over ? WIN_LO : cfg_base;
    size_c = over ? SPAN : cfg_size;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_base  <= '0;
      eff_steps <= '0;
    end else if (load) begin
      eff_base  <= base_c;
      eff_steps <= CNT_W'(size_c >> STRIDE_SHIFT);
    end
  end

  // R6
  span_cap_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (eff_steps <= CNT_W'(SPAN >> STRIDE_SHIFT)));

  // R6
  clamp_base_chk: assert property (@(posedge clk) disable iff (rst)
    (load && (cfg_size > SPAN)) |=> (eff_base == WIN_LO));

endmodule

// File: rtl/mst_addr_gen.sv
module mst_addr_gen #(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int STRIDE_SHIFT = 5,
  parameter int WORD_SHIFT   = 2,
  parameter int CNT_W        = AW - STRIDE_SHIFT,
  parameter logic [DW-1:0] PATTERN = 32'hAAAA_AAAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [AW-1:0]    base,
  output logic [CNT_W-1:0] step,
  output logic [AW-1:0]    addr,
  output logic [DW-1:0]    pattern
);

  localparam int IDX_SH = STRIDE_SHIFT - WORD_SHIFT;
  localparam logic [AW-1:0] STRIDE_BYTES = AW'(1) << STRIDE_SHIFT;

  logic [CNT_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      step_q <= '0;
    end else if (adv) begin
      step_q <= step_q + CNT_W'(1);
    end
  end

  assign step    = step_q;
  assign addr    = base + (AW'(step_q) << STRIDE_SHIFT);
  assign pattern = DW'(AW'(step_q) << IDX_SH) ^ PATTERN;

  // R1
  stride_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (addr == $past(addr) + STRIDE_BYTES));

endmodule

// File: rtl/mst_err_log.sv
module mst_err_log #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CNT_W     = 27,
  parameter int LOG_DEPTH = 3,
  parameter int LSEL_W    = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  parameter int LCNT_W    = $clog2(LOG_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hit,
  input  logic              mismatch,
  input  logic [AW-1:0]     cur_addr,
  input  logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     exp_data,
  input  logic [LSEL_W-1:0] log_sel,
  output logic [CNT_W-1:0]  err_count,
  output logic [AW-1:0]     first_addr,
  output logic [LCNT_W-1:0] log_count,
  output logic [AW-1:0]     log_addr,
  output logic [DW-1:0]     log_rdata,
  output logic [DW-1:0]     log_exp
);

  logic [AW-1:0] rec_addr [LOG_DEPTH];
  logic [DW-1:0] rec_rd   [LOG_DEPTH];
  logic [DW-1:0] rec_exp  [LOG_DEPTH];

  logic fault;
  logic room;

  assign fault = hit && mismatch;
  assign room  = (err_count < CNT_W'(LOG_DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_count  <= '0;
      first_addr <= '0;
      log_count  <= '0;
    end else if (fault) begin
      err_count <= err_count + CNT_W'(1);
      if (err_count == '0) begin
        first_addr <= cur_addr;
      end
      if (room) begin
        log_count <= log_count + LCNT_W'(1);
      end
    end
  end

  // record store: plain write port, no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (fault && room && !clr) begin
      rec_addr[err_count[LSEL_W-1:0]] <= cur_addr;
      rec_rd[err_count[LSEL_W-1:0]]   <= rd_data;
      rec_exp[err_count[LSEL_W-1:0]]  <= exp_data;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      log_addr  <= '0;
      log_rdata <= '0;
      log_exp   <= '0;
    end else if (int'(log_sel) < LOG_DEPTH) begin
      log_addr  <= rec_addr[log_sel];
      log_rdata <= rec_rd[log_sel];
      log_exp   <= rec_exp[log_sel];
    end else begin
      log_addr  <= '0;
      log_rdata <= '0;
      log_exp   <= '0;
    end
  end

  // R5
  log_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(log_count) <= LOG_DEPTH));

  // R4
  first_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((err_count != '0) && !clr) |=> $stable(first_addr));

  // R4
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr) |=> $stable(err_count));

endmodule

// File: rtl/mem_stride_bist.sv
module mem_stride_bist #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int STRIDE_SHIFT = 5,
  parameter int WORD_SHIFT   = 2,
  parameter int LOG_DEPTH    = 3,
  parameter logic [ADDR_W-1:0] WIN_LO  = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] WIN_HI  = 32'h0000_2000,
  parameter logic [DATA_W-1:0] PATTERN = 32'hAAAA_AAAA,
  localparam int CNT_W  = ADDR_W - STRIDE_SHIFT,
  localparam int LSEL_W = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
  localparam int LCNT_W = $clog2(LOG_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CNT_W-1:0]  err_count,
  output logic [ADDR_W-1:0] first_err_addr,
  output logic [CNT_W-1:0]  words_total,
  output logic [LCNT_W-1:0] log_count,
  input  logic [LSEL_W-1:0] log_sel,
  output logic [ADDR_W-1:0] log_addr,
  output logic [DATA_W-1:0] log_rdata,
  output logic [DATA_W-1:0] log_expected
);

  import mst_pkg::*;

  mst_state_e state;

  logic              req_valid_q;
  logic              req_we_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              busy_q;
  logic              done_q;
  logic              pass_q;

  logic [ADDR_W-1:0] eff_base;
  logic [CNT_W-1:0]  eff_steps;
  logic [CNT_W-1:0]  gen_step;
  logic [ADDR_W-1:0] gen_addr;
  logic [DATA_W-1:0] gen_pattern;

  logic load_cfg;
  logic accept;
  logic last_step;
  logic w_acc;
  logic r_done;
  logic gen_clr;
  logic gen_adv;
  logic mismatch;

  always_comb begin
    load_cfg  = (state == MST_IDLE) && start;
    accept    = req_valid_q && mem_req_ready;
    last_step = (gen_step == eff_steps - CNT_W'(1));
    w_acc     = (state == MST_W_WAIT) && accept;
    r_done    = (state == MST_R_RESP) && mem_rsp_valid;
    gen_clr   = load_cfg || (w_acc && last_step);
    gen_adv   = (w_acc || r_done) && !last_step;
    mismatch  = (mem_rsp_data != gen_pattern);
  end

  mst_cfg_clamp #(
    .AW           (ADDR_W),
    .STRIDE_SHIFT (STRIDE_SHIFT),
    .CNT_W        (CNT_W),
    .WIN_LO       (WIN_LO),
    .WIN_HI       (WIN_HI)
  ) u_clamp (
    .clk       (clk),
    .rst       (rst),
    .load      (load_cfg),
    .cfg_base  (cfg_base),
    .cfg_size  (cfg_size),
    .eff_base  (eff_base),
    .eff_steps (eff_steps)
  );

  mst_addr_gen #(
    .AW           (ADDR_W),
    .DW           (DATA_W),
    .STRIDE_SHIFT (STRIDE_SHIFT),
    .WORD_SHIFT   (WORD_SHIFT),
    .CNT_W        (CNT_W),
    .PATTERN      (PATTERN)
  ) u_gen (
    .clk     (clk),
    .rst     (rst),
    .clr     (gen_clr),
    .adv     (gen_adv),
    .base    (eff_base),
    .step    (gen_step),
    .addr    (gen_addr),
    .pattern (gen_pattern)
  );

  mst_err_log #(
    .AW        (ADDR_W),
    .DW        (DATA_W),
    .CNT_W     (CNT_W),
    .LOG_DEPTH (LOG_DEPTH),
    .LSEL_W    (LSEL_W),
    .LCNT_W    (LCNT_W)
  ) u_log (
    .clk        (clk),
    .rst        (rst),
    .clr        (load_cfg),
    .hit        (r_done),
    .mismatch   (mismatch),
    .cur_addr   (gen_addr),
    .rd_data    (mem_rsp_data),
    .exp_data   (gen_pattern),
    .log_sel    (log_sel),
    .err_count  (err_count),
    .first_addr (first_err_addr),
    .log_count  (log_count),
    .log_addr   (log_addr),
    .log_rdata  (log_rdata),
    .log_exp    (log_expected)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= MST_IDLE;
      req_valid_q <= 1'b0;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      pass_q      <= 1'b0;
    end else begin
      case (state)
        MST_IDLE: begin
          if (start) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            pass_q <= 1'b0;
            state  <= MST_W_ISSUE;
          end
        end
        MST_W_ISSUE: begin
          if (eff_steps == '0) begin
            state <= MST_FINISH;
          end else begin
            req_valid_q <= 1'b1;
            req_we_q    <= 1'b1;
            req_addr_q  <= gen_addr;
            req_wdata_q <= gen_pattern;
            state       <= MST_W_WAIT;
          end
        end
        MST_W_WAIT: begin
          if (accept) begin
            req_valid_q <= 1'b0;
            state       <= last_step ? MST_R_ISSUE : MST_W_ISSUE;
          end
        end
        MST_R_ISSUE: begin
          req_valid_q <= 1'b1;
          req_we_q    <= 1'b0;
          req_addr_q  <= gen_addr;
          req_wdata_q <= '0;
          state       <= MST_R_WAIT;
        end
        MST_R_WAIT: begin
          if (accept) begin
            req_valid_q <= 1'b0;
            state       <= MST_R_RESP;
          end
        end
        MST_R_RESP: begin
          if (mem_rsp_valid) begin
            state <= last_step ? MST_FINISH : MST_R_ISSUE;
          end
        end
        MST_FINISH: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pass_q <= (err_count == '0);
          state  <= MST_IDLE;
        end
        default: state <= MST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = req_valid_q;
  assign mem_req_we    = req_we_q;
  assign mem_req_addr  = req_addr_q;
  assign mem_req_wdata = req_wdata_q;
  assign busy          = busy_q;
  assign done          = done_q;
  assign pass          = pass_q;
  assign words_total   = eff_steps;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(pass) && $stable(err_count)));

  // R7
  pass_rule_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass == (err_count == '0)));

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == MST_R_ISSUE) || (state == MST_R_WAIT) || (state == MST_R_RESP)) |->
      !(mem_req_valid && mem_req_we));

endmodule

// File: tb/mem_stride_bist_tb.sv
module mem_stride_bist_tb;

  localparam logic [31:0] WLO  = 32'h0000_1000;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam logic [31:0] PAT  = 32'hAAAA_AAAA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [31:0] cfg_size = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy;
  logic        done;
  logic        pass;
  logic [26:0] err_count;
  logic [31:0] first_err_addr;
  logic [26:0] words_total;
  logic [1:0]  log_count;
  logic [1:0]  log_sel = '0;
  logic [31:0] log_addr;
  logic [31:0] log_rdata;
  logic [31:0] log_expected;

  logic [31:0] mem   [1024];
  logic [31:0] fmask [1024];
  logic        fill_req = 1'b0;
  logic        stall_en = 1'b0;
  logic [1:0]  stall_ctr = '0;
  logic        rd_seen = 1'b0;
  logic        order_bad = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mem_stride_bist u_dut (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .cfg_base       (cfg_base),
    .cfg_size       (cfg_size),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_we     (mem_req_we),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_rsp_valid  (mem_rsp_valid),
    .mem_rsp_data   (mem_rsp_data),
    .busy           (busy),
    .done           (done),
    .pass           (pass),
    .err_count      (err_count),
    .first_err_addr (first_err_addr),
    .words_total    (words_total),
    .log_count      (log_count),
    .log_sel        (log_sel),
    .log_addr       (log_addr),
    .log_rdata      (log_rdata),
    .log_expected   (log_expected)
  );

  // memory model
  logic [31:0] m_off;
  logic        m_in;
  logic [9:0]  m_idx;
  assign m_off = mem_req_addr - WLO;
  assign m_in  = (m_off < 32'h0000_1000);
  assign m_idx = m_off[11:2];
  assign mem_req_ready = !stall_en || (stall_ctr == 2'b11);

  always @(posedge clk) begin
    stall_ctr     <= stall_ctr + 2'd1;
    mem_rsp_valid <= 1'b0;
    if (fill_req) begin
      for (int i = 0; i < 1024; i++) mem[i] <= SENT;
      rd_seen   <= 1'b0;
      order_bad <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        if (m_in) mem[m_idx] <= mem_req_wdata;
        if (rd_seen) order_bad <= 1'b1;
      end else begin
        rd_seen       <= 1'b1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= m_in ? (mem[m_idx] ^ fmask[m_idx]) : 32'h0;
      end
    end
  end

  function automatic logic [31:0] exp_pat(input int k);
    return (32'(k) << 3) ^ PAT;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill_mem();
    @(negedge clk);
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic clear_faults();
    for (int i = 0; i < 1024; i++) fmask[i] = '0;
  endtask

  task automatic start_run(input logic [31:0] b, input logic [31:0] s);
    @(negedge clk);
    cfg_base = b;
    cfg_size = s;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    if (!done) chk("R7 done never rose", 32'(done), 32'd1);
  endtask

  task automatic read_log(input int i, input logic [31:0] ea, input logic [31:0] er,
                          input logic [31:0] ee);
    @(negedge clk);
    log_sel = 2'(i);
    @(negedge clk);
    chk("R5 log address", log_addr, ea);
    chk("R5 log read value", log_rdata, er);
    chk("R5 log expected value", log_expected, ee);
  endtask

  task automatic test_reset();
    chk("R11 busy after reset", 32'(busy), 32'd0);
    chk("R11 done after reset", 32'(done), 32'd0);
    chk("R11 pass after reset", 32'(pass), 32'd0);
    chk("R11 err_count after reset", 32'(err_count), 32'd0);
    chk("R11 req valid after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic test_clean();
    fill_mem();
    start_run(32'h0000_1000, 32'h0000_0400);
    wait_done();
    chk("R7 clean pass", 32'(pass), 32'd1);
    chk("R4 clean err_count", 32'(err_count), 32'd0);
    chk("R8 busy low at done", 32'(busy), 32'd0);
    chk("R10 words_total", 32'(words_total), 32'd32);
    chk("R2 pattern at step 5", mem[40], exp_pat(5));
    chk("R1 pattern at last step", mem[248], exp_pat(31));
    chk("R1 word between strides untouched", mem[41], SENT);
    chk("R1 word past region untouched", mem[256], SENT);
    chk("R3 no write after a read", 32'(order_bad), 32'd0);
  endtask

  task automatic test_errors();
    fill_mem();
    clear_faults();
    fmask[256 + 8*3]  = 32'h0000_0001;
    fmask[256 + 8*7]  = 32'h0000_0100;
    fmask[256 + 8*10] = 32'h0001_0000;
    fmask[256 + 8*20] = 32'h8000_0000;
    stall_en = 1'b1;
    start_run(32'h0000_1400, 32'h0000_0800);
    wait_done();
    stall_en = 1'b0;
    chk("R4 error count", 32'(err_count), 32'd4);
    chk("R4 first error address", first_err_addr, 32'h0000_1460);
    chk("R7 fail verdict", 32'(pass), 32'd0);
    chk("R5 log_count capped", 32'(log_count), 32'd3);
    chk("R3 order under stall", 32'(order_bad), 32'd0);
    read_log(0, 32'h0000_1460, exp_pat(3) ^ 32'h0000_0001, exp_pat(3));
    read_log(1, 32'h0000_14E0, exp_pat(7) ^ 32'h0000_0100, exp_pat(7));
    read_log(2, 32'h0000_1540, exp_pat(10) ^ 32'h0001_0000, exp_pat(10));
    clear_faults();
  endtask

  task automatic test_clamp();
    fill_mem();
    clear_faults();
    fmask[0]    = 32'h0000_0010;
    fmask[1016] = 32'h0000_0020;
    start_run(32'h0000_1400, 32'h0000_1001);
    wait_done();
    chk("R6 clamped words_total", 32'(words_total), 32'd128);
    chk("R6 clamped first error at window low", first_err_addr, 32'h0000_1000);
    chk("R6 clamped error count", 32'(err_count), 32'd2);
    chk("R6 last window word written", mem[1016], exp_pat(127));
    chk("R5 log_count below cap", 32'(log_count), 32'd2);
    read_log(1, 32'h0000_1FE0, exp_pat(127) ^ 32'h0000_0020, exp_pat(127));
    clear_faults();
  endtask

  task automatic test_busy();
    fill_mem();
    stall_en = 1'b1;
    start_run(32'h0000_1000, 32'h0000_0200);
    repeat (10) @(negedge clk);
    cfg_base = 32'h0000_1400;
    cfg_size = 32'h0000_0800;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    wait_done();
    stall_en = 1'b0;
    chk("R8 start while busy ignored", 32'(words_total), 32'd16);
    chk("R8 second region untouched", mem[256], SENT);
    chk("R9 pass under stalls", 32'(pass), 32'd1);
    repeat (15) @(negedge clk);
    chk("R8 done held", 32'(done), 32'd1);
    chk("R8 pass held", 32'(pass), 32'd1);
  endtask

  task automatic test_zero();
    fill_mem();
    start_run(32'h0000_1000, 32'h0000_001F);
    wait_done();
    chk("R10 zero words_total", 32'(words_total), 32'd0);
    chk("R10 zero-size pass", 32'(pass), 32'd1);
    chk("R4 err_count cleared by start", 32'(err_count), 32'd0);
    chk("R10 nothing written", mem[0], SENT);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    clear_faults();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_clean();
    test_errors();
    test_clamp();
    test_busy();
    test_zero();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule